// File: doc/BRIEF.md
# CAN Frame Error Detector

This block sits beside the bit-level logic of a CAN node and watches every sampled bus bit. An outside frame sequencer tells it, through a small field code, which part of the frame the current bit belongs to. A strobe marks each sample. With that code and the node's own role, the block removes stuff bits and runs a CRC-15 over the destuffed frame content. It then reports the five protocol error classes: bit, stuff, CRC, form and acknowledgment.

Each error class has a sticky flag. A flag stays set until software writes a one to its position on the clear port. An interrupt request is raised while any flag whose enable bit is set is active. For every bit that survives destuffing, the block also gives a one-cycle valid strobe together with that bit, so later logic can gather the frame payload.

Top module: `can_err_det`

## Requirements
- R1: The field input uses these codes: 0 idle, 1 start of frame, 2 arbitration, 3 control, 4 data, 5 CRC sequence, 6 CRC delimiter, 7 acknowledge slot, 8 acknowledge delimiter, 9 end of frame. Stuff handling applies in fields 2 to 5. A bit that comes after five equal bits in those fields is dropped as a stuff bit and gives no valid strobe.
- R2: In fields 2 to 5, a sixth consecutive bit of the same level sets the stuff flag, bit 3 of `err_flags`.
- R3: One cycle after each strobe in field 1, or each non-stuff strobe in fields 2 to 5, `dbit_vld` pulses high for one cycle and `dbit` carries the sampled bit. No other strobe gives a pulse.
- R4: While `is_tx` is high, a strobe whose sampled bit differs from the driven bit sets the bit flag, bit 4. While `is_tx` is low, no bit error is flagged.
- R5: A driven recessive (1) bit read back as dominant (0) does not set the bit flag in the arbitration field (2) or the acknowledge slot (7).
- R6: The CRC (generator 0x4599, register cleared at start of frame) runs over the destuffed bits of fields 1 to 4. At the first strobe of the CRC delimiter it is compared with the 15 destuffed bits received in field 5, MSB first. A mismatch sets the CRC flag, bit 2.
- R7: A dominant bit sampled in field 6, 8 or 9 sets the form flag, bit 1.
- R8: While `is_tx` is high, a recessive bit sampled in the acknowledge slot sets the acknowledgment flag, bit 0. In the receive role it does not.
- R9: Flags are cleared only by `clr_we` with a one in `clr_mask` at that bit position. A flag set in the same cycle as its clear stays set. Reset clears all flags.
- R10: `irq` is high exactly when some flag is set and its bit in `irq_en` is also set.
- R11: A new start of frame restarts stuff counting and the CRC. A correct frame that follows an aborted or bad one raises no new error, and flags already set are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One pulse per sampled bus bit |
| rx_bit | input | 1 | Sampled bus level (0 dominant) |
| tx_bit | input | 1 | Level the node is driving |
| is_tx | input | 1 | High while the node is transmitter |
| field | input | 4 | Current frame field code |
| clr_we | input | 1 | Write strobe of the clear port |
| clr_mask | input | 5 | Write-one-to-clear mask |
| irq_en | input | 5 | Per-flag interrupt enable |
| err_flags | output | 5 | Sticky flags: 4 bit, 3 stuff, 2 CRC, 1 form, 0 ack |
| irq | output | 1 | Interrupt request |
| dbit_vld | output | 1 | Destuffed bit valid strobe |
| dbit | output | 1 | Destuffed bit value |

## Verification
The bench sends whole frames with an identifier of all zeros, so stuff bits are inserted over and over, and these stuff bits must produce no valid strobe. A design that passes them on would both pulse `dbit_vld` for them and compute a wrong CRC. A frame whose last CRC bit is flipped must set only the CRC flag, and a clean frame right after it must not. A design that does not restart its CRC at start of frame would flag the clean frame too. The two recessive-read-as-dominant exceptions are exercised: a lost arbitration bit, and a transmitter that receives an acknowledge. A design without these exceptions would set the bit flag on every acknowledged frame. The bench also tests a clear that arrives in the same cycle as a new error, where a design with the wrong priority would lose that error.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

   typedef enum logic [3:0] {
      FLD_IDLE     = 4'd0,
      FLD_SOF      = 4'd1,
      FLD_ARB      = 4'd2,
      FLD_CTRL     = 4'd3,
      FLD_DATA     = 4'd4,
      FLD_CRC      = 4'd5,
      FLD_CRC_DLM  = 4'd6,
      FLD_ACK_SLOT = 4'd7,
      FLD_ACK_DLM  = 4'd8,
      FLD_EOF      = 4'd9
   } fld_e;

   localparam int N_ERR   = 5;
   localparam int E_ACK   = 0;
   localparam int E_FORM  = 1;
   localparam int E_CRC   = 2;
   localparam int E_STUFF = 3;
   localparam int E_BIT   = 4;

endpackage

// File: rtl/can_destuff.sv
module can_destuff
   import can_err_pkg::*;
#(
   parameter int RUN_MAX = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic rx,
   input  fld_e fld,
   output logic keep,
   output logic stuff_err,
   output logic dv,
   output logic db
);

   localparam int CW = $clog2(RUN_MAX + 1);
   localparam logic [CW-1:0] RUN_LIM = CW'(RUN_MAX);

   generate
      if (RUN_MAX < 2) begin : g_bad_run
         $error("can_destuff: RUN_MAX must be at least 2");
      end
   endgenerate

   logic [CW-1:0] run;
   logic          last;
   logic          in_sof;
   logic          in_stuffed;
   logic          is_stuff;

   assign in_sof     = (fld == FLD_SOF);
   assign in_stuffed = (fld inside {FLD_ARB, FLD_CTRL, FLD_DATA, FLD_CRC});
   assign is_stuff   = stb && in_stuffed && (run == RUN_LIM);
   assign stuff_err  = is_stuff && (rx == last);
   assign keep       = stb && (in_sof || (in_stuffed && !is_stuff));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run  <= '0;
         last <= 1'b1;
         dv   <= 1'b0;
         db   <= 1'b1;
      end else begin
         dv <= keep;
         if (keep) db <= rx;
         if (stb) begin
            if (in_sof) begin
               run  <= CW'(1);
               last <= rx;
            end else if (in_stuffed) begin
               if (!is_stuff && rx == last && run != '0) begin
                  run <= run + 1'b1;
               end else begin
                  run  <= CW'(1);
                  last <= rx;
               end
            end else begin
               run <= '0;
            end
         end
      end
   end

   // R1: a stuff-position bit never produces a valid strobe
   a_r1_stuff_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && in_stuffed && run == RUN_LIM) |=> !dv);

   // R2: the run counter never passes the stuff limit
   a_r2_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run <= RUN_LIM);

endmodule

// File: rtl/can_crc_chk.sv
module can_crc_chk
   import can_err_pkg::*;
#(
   parameter int             W    = 15,
   parameter logic [W-1:0]   POLY = 'h4599
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic keep,
   input  logic bit_in,
   input  fld_e fld,
   output logic crc_err
);

   generate
      if (W < 2) begin : g_bad_w
         $error("can_crc_chk: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] acc;
   logic [W-1:0] rcv;
   logic [W-1:0] stepped;
   logic         fb;

   assign fb = acc[W-1] ^ bit_in;

   for (genvar i = 0; i < W; i++) begin : g_step
      if (i == 0) begin : g_lsb
         assign stepped[i] = fb & POLY[i];
      end else begin : g_up
         assign stepped[i] = acc[i-1] ^ (fb & POLY[i]);
      end
   end

   assign crc_err = stb && (fld == FLD_CRC_DLM) && (rcv != acc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
         rcv <= '0;
      end else if (stb && fld == FLD_IDLE) begin
         acc <= '0;
         rcv <= '0;
      end else if (keep) begin
         if (fld == FLD_SOF) begin
            acc <= {W{bit_in}} & POLY;
            rcv <= '0;
         end else if (fld inside {FLD_ARB, FLD_CTRL, FLD_DATA}) begin
            acc <= stepped;
         end else if (fld == FLD_CRC) begin
            rcv <= {rcv[W-2:0], bit_in};
         end
      end
   end

   // R6: the running CRC is frozen while the received CRC field is shifted in
   a_r6_acc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (fld == FLD_CRC) |=> $stable(acc));

endmodule

// File: rtl/can_err_flags.sv
module can_err_flags #(
   parameter int N       = 5,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_we,
   input  logic [N-1:0] clr_mask,
   input  logic [N-1:0] en,
   output logic [N-1:0] flags,
   output logic         irq
);

   generate
      if (N < 1) begin : g_bad_n
         $error("can_err_flags: N must be positive");
      end
   endgenerate

   logic [N-1:0] clr_eff;
   assign clr_eff = clr_we ? clr_mask : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_eff) | set;
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= |(flags & en);
         end
      end else begin : g_irq_comb
         assign irq = |(flags & en);
      end
   endgenerate

   // R9: without a clear write no flag drops
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((flags & $past(flags)) == $past(flags)));

   // R9: a set in the same cycle as a clear wins
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|set) |=> ((flags & $past(set)) == $past(set)));

endmodule

// File: rtl/can_err_det.sv
module can_err_det
   import can_err_pkg::*;
#(
   parameter int                 CRC_W     = 15,
   parameter logic [CRC_W-1:0]   CRC_POLY  = 'h4599,
   parameter int                 STUFF_RUN = 5,
   parameter bit                 IRQ_REG   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             rx_bit,
   input  logic             tx_bit,
   input  logic             is_tx,
   input  logic [3:0]       field,
   input  logic             clr_we,
   input  logic [N_ERR-1:0] clr_mask,
   input  logic [N_ERR-1:0] irq_en,
   output logic [N_ERR-1:0] err_flags,
   output logic             irq,
   output logic             dbit_vld,
   output logic             dbit
);

   fld_e             fld;
   logic             keep;
   logic             stuff_set;
   logic             crc_set;
   logic             form_set;
   logic             ack_set;
   logic             bit_set;
   logic             excused;
   logic [N_ERR-1:0] set_vec;

   assign fld = fld_e'(field);

   can_destuff #(.RUN_MAX(STUFF_RUN)) u_destuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (bit_stb),
      .rx        (rx_bit),
      .fld       (fld),
      .keep      (keep),
      .stuff_err (stuff_set),
      .dv        (dbit_vld),
      .db        (dbit)
   );

   can_crc_chk #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (bit_stb),
      .keep    (keep),
      .bit_in  (rx_bit),
      .fld     (fld),
      .crc_err (crc_set)
   );

   assign form_set = bit_stb && !rx_bit &&
                     (fld inside {FLD_CRC_DLM, FLD_ACK_DLM, FLD_EOF});
   assign ack_set  = bit_stb && is_tx && (fld == FLD_ACK_SLOT) && rx_bit;
   assign excused  = tx_bit && !rx_bit && (fld inside {FLD_ARB, FLD_ACK_SLOT});
   assign bit_set  = bit_stb && is_tx && (rx_bit != tx_bit) && !excused;

   always_comb begin
      set_vec          = '0;
      set_vec[E_ACK]   = ack_set;
      set_vec[E_FORM]  = form_set;
      set_vec[E_CRC]   = crc_set;
      set_vec[E_STUFF] = stuff_set;
      set_vec[E_BIT]   = bit_set;
   end

   can_err_flags #(.N(N_ERR), .IRQ_REG(IRQ_REG)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (set_vec),
      .clr_we   (clr_we),
      .clr_mask (clr_mask),
      .en       (irq_en),
      .flags    (err_flags),
      .irq      (irq)
   );

   // R4: a new bit error only follows a strobe taken as transmitter
   a_r4_bit_tx_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flags[E_BIT]) |-> $past(is_tx && bit_stb));

   // R7: a new form error only follows a dominant sample
   a_r7_form_dominant: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flags[E_FORM]) |-> $past(!rx_bit && bit_stb));

   // R8: a new acknowledgment error only follows a transmitter ack slot
   a_r8_ack_slot: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flags[E_ACK]) |-> $past(is_tx && field == 4'd7));

endmodule

// File: tb/can_err_det_bench.sv
module can_err_det_bench;

   localparam int CLK_PERIOD = 10;

   localparam logic [3:0] F_IDLE = 4'd0, F_SOF = 4'd1, F_ARB = 4'd2, F_CTRL = 4'd3,
                          F_DATA = 4'd4, F_CRC = 4'd5, F_CRCD = 4'd6, F_ACK = 4'd7,
                          F_ACKD = 4'd8, F_EOF = 4'd9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_stb = 1'b0;
   logic       rx_bit = 1'b1;
   logic       tx_bit = 1'b1;
   logic       is_tx = 1'b0;
   logic [3:0] field = 4'd0;
   logic       clr_we = 1'b0;
   logic [4:0] clr_mask = '0;
   logic [4:0] irq_en = '0;
   logic [4:0] err_flags;
   logic       irq;
   logic       dbit_vld;
   logic       dbit;

   int checks = 0;
   int errors = 0;
   logic [4:0] exp_fl = '0;

   typedef struct {
      logic [4:0] fl;
      logic       dv;
      logic       db;
      string      req;
   } item_t;
   item_t exp_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   can_err_det u_can_err_det (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit), .tx_bit(tx_bit),
      .is_tx(is_tx), .field(field), .clr_we(clr_we), .clr_mask(clr_mask),
      .irq_en(irq_en), .err_flags(err_flags), .irq(irq), .dbit_vld(dbit_vld),
      .dbit(dbit)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // driver: one strobed bit, expected result pushed to the scoreboard
   task automatic drive_bit(input logic [3:0] f, input logic r, input logic t,
                            input logic role, input logic edv, input logic edb,
                            input string req, input logic [4:0] clrm);
      item_t it;
      @(negedge clk);
      field = f; rx_bit = r; tx_bit = t; is_tx = role; bit_stb = 1'b1;
      clr_we = (clrm != '0); clr_mask = clrm;
      it.fl = exp_fl; it.dv = edv; it.db = edb; it.req = req;
      exp_q.push_back(it);
      @(negedge clk);
      bit_stb = 1'b0; clr_we = 1'b0; clr_mask = '0;
      field = F_IDLE; rx_bit = 1'b1; tx_bit = 1'b1;
   endtask

   // monitor: compare outputs the cycle after each strobe
   initial begin
      logic s;
      forever begin
         @(posedge clk);
         s = bit_stb;
         @(negedge clk);
         if (s) begin
            if (exp_q.size() == 0) begin
               check("scoreboard underflow", 1, 0);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               check({it.req, " flags"}, err_flags, it.fl);
               check({it.req, " dbit_vld"}, dbit_vld, it.dv);
               if (it.dv) check({it.req, " dbit"}, dbit, it.db);
            end
         end
      end
   end

   task automatic clear(input logic [4:0] m, input string req);
      @(negedge clk);
      clr_we = 1'b1; clr_mask = m;
      exp_fl = exp_fl & ~m;
      @(negedge clk);
      clr_we = 1'b0; clr_mask = '0;
      check(req, err_flags, exp_fl);
   endtask

   function automatic logic [14:0] crc_ref(input logic [0:26] b);
      logic [14:0] c = '0;
      for (int i = 0; i < 27; i++) begin
         logic fb = c[14] ^ b[i];
         c = {c[13:0], 1'b0};
         if (fb) c = c ^ 15'h4599;
      end
      return c;
   endfunction

   function automatic logic [3:0] field_of(input int i);
      if (i == 0)  return F_SOF;
      if (i <= 12) return F_ARB;
      if (i <= 18) return F_CTRL;
      if (i <= 26) return F_DATA;
      return F_CRC;
   endfunction

   task automatic send_frame(input logic [10:0] id, input logic [7:0] dat, input logic role,
                             input logic bad_crc, input logic no_ack, input int lose_idx,
                             input string req);
      logic [0:26] hdr;
      logic [14:0] crcv;
      int          run;
      logic        last;
      hdr = '0;
      for (int k = 0; k < 11; k++) hdr[1 + k] = id[10 - k];
      hdr[18] = 1'b1;
      for (int k = 0; k < 8; k++) hdr[19 + k] = dat[7 - k];
      crcv = crc_ref(hdr);
      run = 0; last = 1'b1;
      for (int i = 0; i < 42; i++) begin
         logic b;
         logic t;
         b = (i < 27) ? hdr[i] : (crcv[41 - i] ^ (bad_crc && i == 41));
         if (i > 0 && run == 5) begin
            drive_bit(field_of(i), !last, !last, role, 1'b0, 1'b0, {req, " stuff R1"}, '0);
            last = !last; run = 1;
         end
         t = (i == lose_idx && b == 1'b0) ? 1'b1 : b;
         drive_bit(field_of(i), b, role ? t : 1'b1, role, 1'b1, b, {req, " R3"}, '0);
         if (i == 0 || b != last) begin run = 1; last = b; end
         else run++;
      end
      if (run == 5)
         drive_bit(F_CRC, !last, !last, role, 1'b0, 1'b0, {req, " stuff R1"}, '0);
      if (bad_crc) exp_fl[2] = 1'b1;
      drive_bit(F_CRCD, 1'b1, 1'b1, role, 1'b0, 1'b0, {req, " R6"}, '0);
      if (role && no_ack) exp_fl[0] = 1'b1;
      drive_bit(F_ACK, no_ack, role ? 1'b1 : 1'b0, role, 1'b0, 1'b0, {req, " R8 R5"}, '0);
      drive_bit(F_ACKD, 1'b1, 1'b1, role, 1'b0, 1'b0, {req, " R7"}, '0);
      for (int k = 0; k < 7; k++)
         drive_bit(F_EOF, 1'b1, 1'b1, role, 1'b0, 1'b0, {req, " R7"}, '0);
      drive_bit(F_IDLE, 1'b1, 1'b1, role, 1'b0, 1'b0, {req, " idle"}, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset flags", err_flags, 5'b0);
      check("R10 reset irq", irq, 1'b0);
      check("R3 reset dbit_vld", dbit_vld, 1'b0);

      // heavy stuffing, receive role, clean frame
      send_frame(11'h000, 8'h00, 1'b0, 1'b0, 1'b0, -1, "R1 R11 clean rx");
      // transmitter, lost-arbitration bit and acknowledge read back: no bit error
      send_frame(11'h555, 8'hA5, 1'b1, 1'b0, 1'b0, 2, "R5 tx exceptions");
      // bad CRC, receive role
      send_frame(11'h123, 8'h3C, 1'b0, 1'b1, 1'b0, -1, "R6 bad crc");
      // next clean frame: CRC restarts, sticky flag kept
      send_frame(11'h0F0, 8'hFF, 1'b0, 1'b0, 1'b0, -1, "R11 after bad crc");
      clear(5'b00100, "R9 w1c crc");

      // receiver seeing no ack: no ack error
      send_frame(11'h7C1, 8'h81, 1'b0, 1'b0, 1'b1, -1, "R8 rx no ack");
      // transmitter seeing no ack
      send_frame(11'h2AA, 8'h10, 1'b1, 1'b0, 1'b1, -1, "R8 tx no ack");
      clear(5'b00001, "R9 w1c ack");

      // form error in end of frame
      exp_fl[1] = 1'b1;
      drive_bit(F_EOF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 eof dominant", '0);
      clear(5'b00010, "R9 w1c form");
      // form error in ack delimiter with a simultaneous clear: set wins
      exp_fl[1] = 1'b1;
      drive_bit(F_ACKD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 R7 set beats clear", 5'b00010);
      clear(5'b00010, "R9 w1c form again");
      exp_fl[1] = 1'b1;
      drive_bit(F_CRCD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 crc delimiter dominant", '0);
      clear(5'b00010, "R9 w1c form crcd");

      // bit errors
      drive_bit(F_ACKD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 rx role mismatch", '0);
      exp_fl[4] = 1'b1;
      drive_bit(F_ACKD, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 tx mismatch", '0);
      clear(5'b10000, "R9 w1c bit");
      drive_bit(F_SOF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R4 sof", '0);
      exp_fl[4] = 1'b1;
      drive_bit(F_ARB, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R5 arb dominant sent recessive read", '0);
      drive_bit(F_IDLE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 idle", '0);

      // stuff error: sixth equal bit
      drive_bit(F_SOF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 sof", '0);
      for (int k = 0; k < 4; k++)
         drive_bit(F_ARB, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 run", '0);
      exp_fl[3] = 1'b1;
      drive_bit(F_ARB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 sixth equal bit", '0);
      drive_bit(F_IDLE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 idle", '0);
      send_frame(11'h001, 8'h7E, 1'b0, 1'b0, 1'b0, -1, "R11 after stuff error");

      // interrupt gating: flags now bit and stuff
      @(negedge clk);
      irq_en = 5'b00111;
      @(negedge clk);
      check("R10 only clear flags enabled", irq, 1'b0);
      irq_en = 5'b01000;
      @(negedge clk);
      check("R10 stuff enabled", irq, 1'b1);
      clear(5'b01000, "R9 w1c stuff");
      check("R10 after clear", irq, 1'b0);
      irq_en = 5'b11111;
      @(negedge clk);
      check("R10 bit flag enabled", irq, 1'b1);
      clear(5'b11111, "R9 clear all");
      check("R10 all clear", irq, 1'b0);

      repeat (4) @(negedge clk);
      check("R3 scoreboard drained", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule